// File: doc/BRIEF.md
# I2C Command and Readback Slave Port

This block is the bus-facing end of a small converter-style peripheral that a host reaches over a two-wire I2C/SMBus link. The host writes a single command byte to the slave, then reads back a stream of bytes: the command echo first, then data. The stream stays open for as long as the host keeps acknowledging. The port answers only its own fixed 7-bit address. It needs no bus clock of its own. Both bus lines are brought into the system clock through two-flop synchronizers, and all START, STOP and clock-edge detection runs on the synchronized copies.

The data line is open drain. The block drives only a pull-low request, and the pad (or the bench) combines that request with the other bus drivers. On the core side, a one-cycle strobe hands over each received command. During a read, the block copies the core's byte from a parallel input whenever it needs the next one, and flags each copy with a one-cycle take pulse. The core then moves its stream forward. The bus rate is limited only by the oversampling ratio. With a system clock in the tens of MHz, rates of a few hundred kbps are comfortable.

Top module: `i2c_cmd_slave`

## Requirements
- R1: While reset is asserted, and directly after it, `sda_pull_o`, `cmd_valid_o` and `rd_take_o` are all 0, so the data line is released.
- R2: The block acknowledges an address byte of 0xF0 (7-bit address 0x78, direction bit 0 = write) or 0xF1 (direction bit 1 = read). It does this by pulling SDA low for the whole high time of the ninth SCL pulse.
- R3: For any other address byte the block does not acknowledge. It then ignores every further bit on the bus, including a later 0xF0 sent without a new START, until the next START.
- R4: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A repeated START with no STOP in between restarts the address phase.
- R5: In a write, the first byte after the address is taken most significant bit first and acknowledged. At the falling SCL edge that ends its eighth bit, it appears on `cmd_byte_o` together with a one-cycle `cmd_valid_o` pulse.
- R6: Further bytes in the same write transaction are not acknowledged and raise no `cmd_valid_o`.
- R7: In a read, the block loads `rd_data_i` at the falling SCL edge that ends the address acknowledge, and after each byte the master acknowledges. Every load gives exactly one one-cycle `rd_take_o` pulse, and each loaded byte goes out most significant bit first.
- R8: After the master answers a read byte with NACK, the block loads no further bytes and keeps SDA released until the next START.
- R9: The block changes its SDA pull only while SCL is low, so the bus never sees a slave-made START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_pull_o | output | 1 | 1 = pull the data line low |
| cmd_valid_o | output | 1 | One-cycle strobe: a command byte was received |
| cmd_byte_o | output | 8 | Last command byte received |
| rd_data_i | input | 8 | Next byte of the core's readback stream |
| rd_take_o | output | 1 | One-cycle strobe: `rd_data_i` was copied for transmission |

## Verification
The bench sends address bytes that are one bit off the device address. A design that compares the wrong bits would acknowledge these, or would miss the real address. After a mismatch, the bench sends a byte equal to the write address but with no START. A design that resynchronizes on any byte boundary would acknowledge it. The bench also sends a second byte after the command. A design that accepts it would raise a second command strobe. On reads, the bench checks the number of take pulses and that the line stays high after NACK. A design that is off by one bit would shift the data, and one that keeps streaming after NACK would drive zeros into a byte the master clocks without a START. A bench monitor flags any slave-side SDA change while SCL is high.

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h78
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_byte_o,
  input  logic [7:0] rd_data_i,
  output logic       rd_take_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK, S_TX, S_MACK
  } st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  st_t        st;
  logic [2:0] cnt;
  logic [7:0] sr, tx;
  logic       full, rw, got_cmd, mnack, pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end
  end

  logic scl_now, sda_now, scl_rise, scl_fall, start_det, stop_det;
  assign scl_now   = scl_sy[1];
  assign sda_now   = sda_sy[1];
  assign scl_rise  = scl_now & ~scl_q;
  assign scl_fall  = ~scl_now & scl_q;
  assign start_det = scl_now & scl_q & sda_q & ~sda_now;
  assign stop_det  = scl_now & scl_q & ~sda_q & sda_now;

  assign sda_pull_o = pull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      sr          <= '0;
      tx          <= '0;
      full        <= 1'b0;
      rw          <= 1'b0;
      got_cmd     <= 1'b0;
      mnack       <= 1'b1;
      pull        <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_byte_o  <= '0;
      rd_take_o   <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      rd_take_o   <= 1'b0;
      if (start_det) begin
        st      <= S_ADDR;
        cnt     <= '0;
        full    <= 1'b0;
        pull    <= 1'b0;
        got_cmd <= 1'b0;
      end else if (stop_det) begin
        st   <= S_IDLE;
        full <= 1'b0;
        pull <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD: begin
            if (scl_rise) begin
              sr   <= {sr[6:0], sda_now};
              cnt  <= cnt + 3'd1;
              full <= (cnt == 3'd7);
            end else if (scl_fall && full) begin
              full <= 1'b0;
              if (st == S_ADDR) begin
                if (sr[7:1] == DEV_ADDR) begin
                  rw   <= sr[0];
                  pull <= 1'b1;
                  st   <= S_AACK;
                end else begin
                  st <= S_IDLE;
                end
              end else if (!got_cmd) begin
                got_cmd     <= 1'b1;
                cmd_byte_o  <= sr;
                cmd_valid_o <= 1'b1;
                pull        <= 1'b1;
                st          <= S_CACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                tx        <= rd_data_i;
                rd_take_o <= 1'b1;
                pull      <= ~rd_data_i[7];
                st        <= S_TX;
              end else begin
                pull <= 1'b0;
                st   <= S_CMD;
              end
            end
          end
          S_CACK: begin
            if (scl_fall) begin
              pull <= 1'b0;
              cnt  <= '0;
              st   <= S_CMD;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                pull <= 1'b0;
                st   <= S_MACK;
              end else begin
                cnt  <= cnt + 3'd1;
                tx   <= {tx[6:0], 1'b0};
                pull <= ~tx[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              mnack <= sda_now;
            end else if (scl_fall) begin
              cnt <= '0;
              if (!mnack) begin
                tx        <= rd_data_i;
                rd_take_o <= 1'b1;
                pull      <= ~rd_data_i[7];
                st        <= S_TX;
              end else begin
                pull <= 1'b0;
                st   <= S_IDLE;
              end
            end
          end
          default: pull <= 1'b0;
        endcase
      end
    end
  end

  a_r9_pull_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) && !$past(start_det) && !$past(stop_det)
      |-> !$past(scl_now));

  a_r5_cmd_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  a_r7_take_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take_o |=> !rd_take_o);

  a_r7_take_not_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_take_o && cmd_valid_o));

  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    $past(st == S_IDLE) && (st == S_IDLE) |-> !sda_pull_o);

  a_r6_cmd_once_per_txn: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |-> $past(st == S_CMD));

endmodule

// File: tb/i2c_cmd_slave_tb.sv
module i2c_cmd_slave_tb_top;
  localparam int Q = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [7:0] rd_data;
  logic sda_pull, cmd_valid, rd_take;
  logic [7:0] cmd_byte;
  logic sda_bus;

  assign sda_bus = sda_m & ~sda_pull;

  always #4 clk = ~clk;

  i2c_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .cmd_valid_o(cmd_valid), .cmd_byte_o(cmd_byte),
    .rd_data_i(rd_data), .rd_take_o(rd_take)
  );

  logic [7:0] rd_vals [8];
  int rd_idx = 0;
  int n_cmd = 0;
  logic [7:0] last_cmd = 8'h00;
  int viol = 0;
  logic prev_pull = 1'b0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign rd_data = rd_vals[rd_idx[2:0]];

  initial begin
    rd_vals[0] = 8'hC3; rd_vals[1] = 8'h9A; rd_vals[2] = 8'h2D; rd_vals[3] = 8'h77;
    rd_vals[4] = 8'h81; rd_vals[5] = 8'h4E; rd_vals[6] = 8'hB0; rd_vals[7] = 8'h15;
  end

  always @(posedge clk) begin
    if (rd_take) rd_idx <= rd_idx + 1;
    if (cmd_valid) begin
      n_cmd    <= n_cmd + 1;
      last_cmd <= cmd_byte;
    end
    if (rst_n && (sda_pull != prev_pull) && scl) viol <= viol + 1;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(output logic s);
    w(Q); scl = 1'b1; w(Q); s = sda_bus; w(Q); scl = 1'b0; w(4);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(4);
  endtask

  task automatic i2c_rstart;
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(4);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic wb(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; bit_clk(s);
    end
    sda_m = 1'b1; bit_clk(s);
    ack = ~s;
  endtask

  task automatic rb(input logic ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; bit_clk(s); b[i] = s;
    end
    sda_m = ~ack; bit_clk(s); sda_m = 1'b1;
  endtask

  // {address byte, command byte, expect address ACK, expect command accepted}
  localparam logic [17:0] VEC [7] = '{
    {8'hF0, 8'hA5, 1'b1, 1'b1},
    {8'hF0, 8'h3C, 1'b1, 1'b1},
    {8'hE0, 8'h55, 1'b0, 1'b0},
    {8'hF2, 8'h11, 1'b0, 1'b0},
    {8'h78, 8'hF0, 1'b0, 1'b0},
    {8'hF0, 8'h00, 1'b1, 1'b1},
    {8'hF0, 8'hFF, 1'b1, 1'b1}
  };

  initial begin
    logic ack;
    logic [7:0] b;
    int n0, t0;
    w(3);
    chk("R1 pull in reset", sda_pull, 1'b0);
    chk("R1 cmd_valid in reset", cmd_valid, 1'b0);
    chk("R1 rd_take in reset", rd_take, 1'b0);
    rst_n = 1'b1;
    w(10);
    chk("R1 pull after reset", sda_pull, 1'b0);

    foreach (VEC[k]) begin
      n0 = n_cmd;
      i2c_start;
      wb(VEC[k][17:10], ack);
      chk(VEC[k][1] ? "R2 address ack" : "R3 address mismatch nack", ack, VEC[k][1]);
      wb(VEC[k][9:2], ack);
      chk(VEC[k][0] ? "R5 command ack" : "R3 ignored after mismatch", ack, VEC[k][0]);
      i2c_stop;
      w(10);
      chk("R5 command strobe count", n_cmd - n0, VEC[k][0]);
      if (VEC[k][0]) chk("R5 command value", last_cmd, VEC[k][9:2]);
    end

    // R7/R8: read stream, ACK twice then NACK
    t0 = rd_idx;
    i2c_start;
    wb(8'hF1, ack);
    chk("R2 read address ack", ack, 1'b1);
    rb(1'b1, b); chk("R7 read byte 0", b, rd_vals[t0]);
    rb(1'b1, b); chk("R7 read byte 1", b, rd_vals[t0+1]);
    rb(1'b0, b); chk("R7 read byte 2", b, rd_vals[t0+2]);
    chk("R7 take count", rd_idx - t0, 3);
    rb(1'b0, b);
    chk("R8 line released after nack", b, 8'hFF);
    chk("R8 no take after nack", rd_idx - t0, 3);
    i2c_stop;

    // R6: extra byte in a write
    n0 = n_cmd;
    i2c_start;
    wb(8'hF0, ack);
    wb(8'h5A, ack);
    chk("R5 command ack", ack, 1'b1);
    wb(8'h66, ack);
    chk("R6 extra byte nack", ack, 1'b0);
    i2c_stop;
    w(10);
    chk("R6 single strobe", n_cmd - n0, 1);
    chk("R6 command kept", last_cmd, 8'h5A);

    // R4: repeated START from write into read
    n0 = n_cmd;
    t0 = rd_idx;
    i2c_start;
    wb(8'hF0, ack);
    wb(8'h81, ack);
    i2c_rstart;
    wb(8'hF1, ack);
    chk("R4 repeated start address ack", ack, 1'b1);
    rb(1'b0, b);
    chk("R4 read after repeated start", b, rd_vals[t0[2:0]]);
    i2c_stop;
    w(10);
    chk("R4 command before repeated start", last_cmd, 8'h81);
    chk("R4 strobe count", n_cmd - n0, 1);

    chk("R9 slave pull changed with scl high", viol, 0);
    chk("R1 idle release at end", sda_pull, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 180000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule